// File: doc/BRIEF.md
# Asynchronous Atomic Response Engine

This block takes 64-bit fetch-and-add command words from a requester and turns each into a single request to an atomic register file. It does not send the prior value back to the requester. It writes that value, as one 64-bit word, into a local scratchpad. The scratchpad slot is chosen by a field inside the command. The requester issues commands and moves on, and later reads the slot it named.

The command word has fixed fields. Bits 63:56 give the scratchpad slot in 8-byte units. Bits 55:48 give the response length in 64-bit words. Bits 35:14 carry a signed 22-bit increment. Bit 13 is the tag-wait flag. Bits 12:11 give the operand size code. Bits 10:0 give the register byte address. Bits 47:36 are reserved.

Several requests can be outstanding at the register file. The register file answers them in request order. A small in-order tag queue pairs each answer with its slot and operand size. Sub-64-bit results are sign-extended before they are stored. A tag-wait timeout reported by the register file is stored as an invalid flag in bit 63 of the word.

Top module: `async_atomic_engine`

## Requirements
- R1: The scratchpad byte address of each stored word is command bits 63:56 shifted left by three, so its three low bits are always zero.
- R2: A command whose bits 55:48 are not 1, or whose reserved bits 47:36 are not all zero, is malformed. It is accepted at once (`cmd_ready` high) and issues no register-file request. `cmd_err` is high for exactly the cycle after its acceptance. `cmd_err` is low after any other cycle.
- R3: A well-formed command issues one request with these fields:
  - the address equal to bits 10:0;
  - the size code equal to bits 12:11;
  - the tag-wait flag equal to bit 13;
  - the increment equal to bits 35:14 sign-extended to 64 bits.
- R4: When the register file flags a timeout, the stored word has bit 63 set, and its bits 62:0 carry no meaning. Otherwise bit 63 is clear.
- R5: Without a timeout, bits 62:0 of the stored word depend on the size code of the command:
  - code 0: response bits 7:0 sign-extended;
  - code 1: response bits 15:0 sign-extended;
  - code 2: response bits 31:0 sign-extended;
  - code 3: response bits 62:0 unchanged.
- R6: Up to DEPTH requests may be outstanding. With DEPTH outstanding, `cmd_ready` and `rf_req_valid` are low for well-formed commands. Stored words appear in the order their commands were issued.
- R7: A scratchpad write happens exactly one cycle after each register-file response, and at no other time.
- R8: While reset is asserted and after it, with no activity, `sp_wr_en` and `cmd_err` are low.
- R9: For a well-formed command with fewer than DEPTH requests outstanding, `cmd_ready` follows `rf_req_ready`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word offered |
| cmd_ready | output | 1 | Command word taken this cycle |
| cmd_word | input | 64 | Asynchronous atomic command |
| rf_req_valid | output | 1 | Request to the register file |
| rf_req_ready | input | 1 | Register file takes the request |
| rf_req_addr | output | 11 | Register byte address |
| rf_req_size | output | 2 | Operand size code |
| rf_req_tagwait | output | 1 | Wait for the pending tag switch |
| rf_req_incr | output | 64 | Sign-extended increment |
| rf_rsp_valid | input | 1 | In-order response from the register file |
| rf_rsp_data | input | 63 | Prior register value, low 63 bits |
| rf_rsp_timeout | input | 1 | Tag-wait timed out |
| sp_wr_en | output | 1 | Scratchpad write strobe |
| sp_wr_addr | output | 11 | Scratchpad byte address |
| sp_wr_data | output | 64 | Stored word: invalid flag and data |
| cmd_err | output | 1 | Malformed command pulse |

## Verification
Directed traffic fills the queue to DEPTH with no responses, to expose a missing full check. It then drains with one response per size code, using sign-bit-set and sign-bit-clear values, plus one timeout. This separates the four extension widths from one another and from the timeout path.

Malformed commands use length 0, length 2 and a nonzero reserved field. This shows that each malformed case is rejected on its own condition.

A long random phase follows. Ready, response timing, slots, sizes and data are all randomized. The random mix of ready and response timing catches ordering and pairing faults that directed traffic misses, such as a response matched to the wrong slot.

// File: rtl/aae_pkg.sv
// Package: shared command layout, size codes and tag type for the
// asynchronous atomic response engine. Field positions are fixed by the
// command format and must not move.
package aae_pkg;

    localparam int CMD_W      = 64;
    localparam int SLOT_W     = 8;
    localparam int LEN_W      = 8;
    localparam int INCR_W     = 22;
    localparam int REG_AW     = 11;
    localparam int RSV_W      = 12;
    localparam int DATA_W     = 63;
    localparam int SP_AW      = SLOT_W + 3;

    localparam int SLOT_LO    = 56;
    localparam int LEN_LO     = 48;
    localparam int RSV_LO     = 36;
    localparam int INCR_LO    = 14;
    localparam int TW_BIT     = 13;
    localparam int SIZE_LO    = 11;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } aae_size_e;

    // decoded command fields
    typedef struct packed {
        logic [SLOT_W-1:0]  slot;
        logic               well_formed;
        logic [CMD_W-1:0]   incr;
        logic               tagwait;
        aae_size_e          size;
        logic [REG_AW-1:0]  reg_addr;
    } aae_cmd_t;

    // what the tag queue remembers per outstanding request
    typedef struct packed {
        logic [SLOT_W-1:0]  slot;
        aae_size_e          size;
    } aae_tag_t;

endpackage

// File: rtl/aae_cmd_decode.sv
// Module: aae_cmd_decode
// Splits a 64-bit command word into its fields and judges whether it is
// well formed (length of one word, reserved bits clear).
// Assumes: purely combinational, no state.
module aae_cmd_decode
    import aae_pkg::*;
(
    input  logic [CMD_W-1:0] word,
    output aae_cmd_t         cmd
);

    localparam logic [LEN_W-1:0] ONE_WORD = LEN_W'(1);

    logic [LEN_W-1:0]  len_f;
    logic [RSV_W-1:0]  rsv_f;
    logic [INCR_W-1:0] incr_f;

    // field extraction and sign extension of the increment
    always_comb begin
        len_f            = word[LEN_LO +: LEN_W];
        rsv_f            = word[RSV_LO +: RSV_W];
        incr_f           = word[INCR_LO +: INCR_W];
        cmd.slot         = word[SLOT_LO +: SLOT_W];
        cmd.well_formed  = (len_f == ONE_WORD) && (rsv_f == '0);
        cmd.incr         = {{(CMD_W-INCR_W){incr_f[INCR_W-1]}}, incr_f};
        cmd.tagwait      = word[TW_BIT];
        cmd.size         = aae_size_e'(word[SIZE_LO +: 2]);
        cmd.reg_addr     = word[REG_AW-1:0];
    end

endmodule

// File: rtl/aae_tag_fifo.sv
// Module: aae_tag_fifo
// In-order queue of slot/size tags, one per request still waiting for
// its response. Push and pop may happen in the same cycle.
// Assumes: caller never pushes when full nor pops when empty.
module aae_tag_fifo
    import aae_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  aae_tag_t  push_tag,
    input  logic      pop,
    output aae_tag_t  head,
    output logic      full,
    output logic      empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    aae_tag_t           store [DEPTH];
    logic [PTR_W-1:0]   wr_ptr;
    logic [PTR_W-1:0]   rd_ptr;
    logic [CNT_W-1:0]   cnt;

    // status flags from the occupancy count
    always_comb begin
        full  = (cnt == CNT_W'(DEPTH));
        empty = (cnt == '0);
        head  = store[rd_ptr];
    end

    // pointer and occupancy update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // tag storage, one entry per slot
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store[i] <= '0;
            end else if (push && (wr_ptr == PTR_W'(i))) begin
                store[i] <= push_tag;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);                                            // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);                                            // R6
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CNT_W'(DEPTH));                                      // R6

endmodule

// File: rtl/aae_rsp_pack.sv
// Module: aae_rsp_pack
// Builds the 64-bit scratchpad word from a register-file response: an
// invalid flag on top and the prior value sign-extended to 63 bits.
// Assumes: data bits are zeroed on timeout; the requester ignores them.
module aae_rsp_pack
    import aae_pkg::*;
(
    input  aae_size_e          size,
    input  logic [DATA_W-1:0]  data,
    input  logic               timeout,
    output logic [CMD_W-1:0]   word
);

    logic [DATA_W-1:0] ext;

    // sign extension chosen by operand size
    always_comb begin
        case (size)
            SZ_BYTE: ext = {{(DATA_W-8){data[7]}},   data[7:0]};
            SZ_HALF: ext = {{(DATA_W-16){data[15]}}, data[15:0]};
            SZ_WORD: ext = {{(DATA_W-32){data[31]}}, data[31:0]};
            default: ext = data;
        endcase
        word = timeout ? {1'b1, {DATA_W{1'b0}}} : {1'b0, ext};
    end

endmodule

// File: rtl/async_atomic_engine.sv
// Module: async_atomic_engine
// Accepts asynchronous atomic commands, forwards well-formed ones to the
// register file and writes each in-order response into the scratchpad
// slot the command named. Malformed commands are dropped with a pulse.
// Assumes: the register file answers requests strictly in issue order.
module async_atomic_engine
    import aae_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [63:0]        cmd_word,
    output logic               rf_req_valid,
    input  logic               rf_req_ready,
    output logic [10:0]        rf_req_addr,
    output logic [1:0]         rf_req_size,
    output logic               rf_req_tagwait,
    output logic [63:0]        rf_req_incr,
    input  logic               rf_rsp_valid,
    input  logic [62:0]        rf_rsp_data,
    input  logic               rf_rsp_timeout,
    output logic               sp_wr_en,
    output logic [10:0]        sp_wr_addr,
    output logic [63:0]        sp_wr_data,
    output logic               cmd_err
);

    aae_cmd_t          cmd;
    aae_tag_t          head;
    aae_tag_t          new_tag;
    logic              q_full;
    logic              q_empty;
    logic              push;
    logic [CMD_W-1:0]  packed_word;

    aae_cmd_decode u_decode (
        .word (cmd_word),
        .cmd  (cmd)
    );

    // request side: pass decoded fields through, hold back when queue full
    always_comb begin
        rf_req_valid   = cmd_valid && cmd.well_formed && !q_full;
        cmd_ready      = cmd.well_formed ? (rf_req_ready && !q_full) : 1'b1;
        rf_req_addr    = cmd.reg_addr;
        rf_req_size    = cmd.size;
        rf_req_tagwait = cmd.tagwait;
        rf_req_incr    = cmd.incr;
        push           = rf_req_valid && rf_req_ready;
        new_tag.slot   = cmd.slot;
        new_tag.size   = cmd.size;
    end

    aae_tag_fifo #(.DEPTH(DEPTH)) u_tags (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .push_tag (new_tag),
        .pop      (rf_rsp_valid),
        .head     (head),
        .full     (q_full),
        .empty    (q_empty)
    );

    aae_rsp_pack u_pack (
        .size    (head.size),
        .data    (rf_rsp_data),
        .timeout (rf_rsp_timeout),
        .word    (packed_word)
    );

    // scratchpad write and malformed-command pulse, one cycle after cause
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_wr_en   <= 1'b0;
            sp_wr_addr <= '0;
            sp_wr_data <= '0;
            cmd_err    <= 1'b0;
        end else begin
            sp_wr_en <= rf_rsp_valid;
            if (rf_rsp_valid) begin
                sp_wr_addr <= {head.slot, 3'b000};
                sp_wr_data <= packed_word;
            end
            cmd_err <= cmd_valid && !cmd.well_formed;
        end
    end

    AST_RSP_HAS_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rsp_valid |-> !q_empty);                                 // R6
    AST_ERR_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(!push));                                  // R2
    AST_INVALID_TRACKS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr_en |-> (sp_wr_data[63] == $past(rf_rsp_timeout)));    // R4
    AST_WR_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rsp_valid |=> sp_wr_en);                                 // R7
    AST_SLOT_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        sp_wr_en |-> (sp_wr_addr[2:0] == 3'b000));                  // R1

endmodule

// File: tb/tb_async_atomic_engine.sv
`timescale 1ns/1ps
// Bench: directed corner cases then seeded random traffic; an in-bench
// register-file model answers in order, and expected words come from
// bench functions written from the requirements.
module tb_async_atomic_engine;

    localparam int DEPTH = 4;

    typedef struct {
        logic [7:0] slot;
        logic [1:0] size;
    } pend_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [63:0] cmd_word = '0;
    logic        rf_req_valid;
    logic        rf_req_ready = 1'b0;
    logic [10:0] rf_req_addr;
    logic [1:0]  rf_req_size;
    logic        rf_req_tagwait;
    logic [63:0] rf_req_incr;
    logic        rf_rsp_valid = 1'b0;
    logic [62:0] rf_rsp_data = '0;
    logic        rf_rsp_timeout = 1'b0;
    logic        sp_wr_en;
    logic [10:0] sp_wr_addr;
    logic [63:0] sp_wr_data;
    logic        cmd_err;

    int total = 0;
    int fails = 0;
    int cycles = 0;
    pend_t pending[$];
    bit          rsp_prev = 0;
    logic [62:0] rsp_prev_d = '0;
    bit          rsp_prev_to = 0;
    bit          err_prev = 0;

    always #4 clk = ~clk;

    async_atomic_engine #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_word(cmd_word),
        .rf_req_valid(rf_req_valid), .rf_req_ready(rf_req_ready),
        .rf_req_addr(rf_req_addr), .rf_req_size(rf_req_size),
        .rf_req_tagwait(rf_req_tagwait), .rf_req_incr(rf_req_incr),
        .rf_rsp_valid(rf_rsp_valid), .rf_rsp_data(rf_rsp_data),
        .rf_rsp_timeout(rf_rsp_timeout),
        .sp_wr_en(sp_wr_en), .sp_wr_addr(sp_wr_addr),
        .sp_wr_data(sp_wr_data), .cmd_err(cmd_err)
    );

    function automatic logic [63:0] mk_cmd(logic [7:0] slot, logic [7:0] len,
            logic [11:0] rsv, logic [21:0] incr, logic tw, logic [1:0] sz,
            logic [10:0] addr);
        return {slot, len, rsv, incr, tw, sz, addr};
    endfunction

    function automatic logic [63:0] exp_word(logic [1:0] sz, logic [62:0] d, bit to);
        logic [62:0] e;
        if (to) return {1'b1, 63'd0};
        case (sz)
            2'd0: e = {{55{d[7]}}, d[7:0]};
            2'd1: e = {{47{d[15]}}, d[15:0]};
            2'd2: e = {{31{d[31]}}, d[31:0]};
            default: e = d;
        endcase
        return {1'b0, e};
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    // one cycle: check registered outputs, drive inputs, check handshake
    task automatic step(bit cv, logic [63:0] cw, bit rrdy, bit rv_req,
                        logic [62:0] rd, bit rto);
        bit rv;
        bit ok_cmd;
        bit exp_rdy;
        pend_t p;
        logic [63:0] ew;
        if (rsp_prev) begin
            p = pending.pop_front();
            ew = exp_word(p.size, rsp_prev_d, rsp_prev_to);
            chk(sp_wr_en == 1'b1, "R7 write strobe", 64'(sp_wr_en), 64'd1);
            chk(sp_wr_addr == {p.slot, 3'b000}, "R1 slot address",
                64'(sp_wr_addr), 64'({p.slot, 3'b000}));
            if (rsp_prev_to)
                chk(sp_wr_data[63] == 1'b1, "R4 invalid flag", sp_wr_data, ew);
            else
                chk(sp_wr_data == ew, "R5 R6 stored word", sp_wr_data, ew);
        end else begin
            chk(sp_wr_en == 1'b0, "R7 no stray write", 64'(sp_wr_en), 64'd0);
        end
        chk(cmd_err == err_prev, "R2 error pulse", 64'(cmd_err), 64'(err_prev));

        rv = rv_req && (pending.size() > 0);
        cmd_valid = cv; cmd_word = cw; rf_req_ready = rrdy;
        rf_rsp_valid = rv; rf_rsp_data = rd; rf_rsp_timeout = rto;
        #1;
        ok_cmd = (cw[55:48] == 8'd1) && (cw[47:36] == 12'd0);
        err_prev = cv && !ok_cmd;
        if (cv && !ok_cmd) begin
            chk(cmd_ready == 1'b1, "R2 malformed accepted", 64'(cmd_ready), 64'd1);
            chk(rf_req_valid == 1'b0, "R2 no request", 64'(rf_req_valid), 64'd0);
        end
        if (cv && ok_cmd) begin
            exp_rdy = rrdy && (pending.size() < DEPTH);
            chk(cmd_ready == exp_rdy, "R6 R9 ready", 64'(cmd_ready), 64'(exp_rdy));
            chk(rf_req_valid == (pending.size() < DEPTH), "R6 request valid",
                64'(rf_req_valid), 64'(pending.size() < DEPTH));
            if (exp_rdy) begin
                chk(rf_req_addr == cw[10:0] && rf_req_size == cw[12:11] &&
                    rf_req_tagwait == cw[13], "R3 request fields",
                    64'({rf_req_tagwait, rf_req_size, rf_req_addr}), 64'(cw[13:0]));
                chk(rf_req_incr == {{42{cw[35]}}, cw[35:14]}, "R3 increment",
                    rf_req_incr, {{42{cw[35]}}, cw[35:14]});
                p.slot = cw[63:56]; p.size = cw[12:11];
                pending.push_back(p);
            end
        end
        rsp_prev = rv; rsp_prev_d = rd; rsp_prev_to = rto;
        @(negedge clk);
    endtask

    // watchdog: a hung run counts as a failure and still reports
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            total++; fails++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
            summary();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(sp_wr_en == 1'b0, "R8 reset write", 64'(sp_wr_en), 64'd0);
        chk(cmd_err == 1'b0, "R8 reset error", 64'(cmd_err), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        step(0, '0, 0, 0, '0, 0);
        step(0, '0, 0, 0, '0, 0);

        // R6: fill to DEPTH with no responses, then one more is held back
        for (int i = 0; i < DEPTH; i++)
            step(1, mk_cmd(8'(i + 1), 8'd1, 12'd0, 22'h3FFFFF - 22'(i), 1'(i), 2'(i),
                 11'(8 * i)), 1, 0, '0, 0);
        step(1, mk_cmd(8'h77, 8'd1, 12'd0, 22'h000005, 0, 2'd3, 11'h40), 1, 0, '0, 0);
        // R5 each size with sign bit set or clear; R4 a timeout
        step(0, '0, 0, 1, 63'h80, 0);
        step(0, '0, 0, 1, 63'h7FFF, 0);
        step(0, '0, 0, 1, 63'h1234_8000_0000, 1);
        step(1, mk_cmd(8'hFF, 8'd1, 12'd0, 22'h1, 0, 2'd2, 11'h7FC), 1, 1,
             63'h4000_0000_0000_0001, 0);
        step(0, '0, 0, 1, 63'h0000_0000_8000_0000, 0);
        step(0, '0, 0, 0, '0, 0);
        // R2 malformed: length 0, length 2, reserved bits set
        step(1, mk_cmd(8'h10, 8'd0, 12'd0, 22'd9, 0, 2'd0, 11'd1), 0, 0, '0, 0);
        step(1, mk_cmd(8'h11, 8'd2, 12'd0, 22'd9, 0, 2'd0, 11'd1), 1, 0, '0, 0);
        step(1, mk_cmd(8'h12, 8'd1, 12'h800, 22'd9, 0, 2'd0, 11'd1), 1, 0, '0, 0);
        step(0, '0, 0, 0, '0, 0);

        // random traffic
        for (int n = 0; n < 4000; n++) begin
            logic [7:0]  len;
            logic [11:0] rsv;
            int r;
            r = $urandom_range(0, 99);
            len = (r < 8) ? 8'($urandom_range(0, 255)) : 8'd1;
            rsv = (r > 95) ? 12'($urandom) : 12'd0;
            step($urandom_range(0, 99) < 60,
                 mk_cmd(8'($urandom), len, rsv, 22'($urandom), 1'($urandom),
                        2'($urandom), 11'($urandom)),
                 $urandom_range(0, 99) < 70,
                 $urandom_range(0, 99) < 55,
                 {31'($urandom), 32'($urandom)},
                 $urandom_range(0, 99) < 15);
        end
        for (int n = 0; n < DEPTH + 4; n++)
            step(0, '0, 0, 1, {31'($urandom), 32'($urandom)}, 0);
        step(0, '0, 0, 0, '0, 0);
        summary();
    end

endmodule